// File: doc/BRIEF.md
# Tag-Based Reservation Station Array

This block is the scheduling core of an out-of-order execution engine. It keeps a small pool of reservation stations and a register status table. An instruction is accepted through the issue port. It takes the lowest-numbered free station. Each of its two source operands is either read as a value from the register file, or renamed to the tag of the station that will later produce that value. Station tags run from 1 to the number of stations. Tag zero means "no pending producer". The destination register's status entry then takes the new station's tag.

A single result bus carries one (tag, value) broadcast per cycle. In that same cycle, every station waiting on the tag copies the value. A register whose status still names that tag takes the value and clears its status to zero. The station that made the result becomes free again. A station whose two operands are both present is ready. The dispatch port offers the lowest-index ready station to a functional unit and hands it over when the unit signals ready. The functional units are outside this block, and so are retirement and memory.

Top module: `rs_array`

## Requirements
- R1: After reset every station is free, `iss_ready` is 1 and `dsp_valid` is 0, every register holds value 0 with no pending producer.
- R2: An accepted issue takes the lowest-index free station; `iss_tag` equals that station's index plus one (tags 1..N, 0 never used).
- R3: A source register with no pending producer supplies its register-file value to the station at issue.
- R4: A source register with a pending producer makes the station wait on that producer's tag; the broadcast value with a matching tag becomes the operand.
- R5: All stations waiting on a broadcast tag capture its value in the same cycle.
- R6: `dsp_valid` is 1 only while some station holds both operands and has not been dispatched; the lowest-index such station is offered, and it is taken only in a cycle with `dsp_ready` = 1, one per cycle.
- R7: When every station is occupied `iss_ready` is 0 and an issue request changes neither the stations nor the register status.
- R8: A dispatched station becomes free in the cycle after the broadcast that carries its tag.
- R9: A broadcast clears a register's pending status and writes its value only if the register's status tag equals the broadcast tag; a later writer's tag is kept.
- R10: If an operand's producer broadcasts in the same cycle the consumer issues, the consumer takes the broadcast value directly and starts with that operand present.
- R11: A register cleared by a broadcast supplies the broadcast value to instructions issued afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one station is free |
| iss_op | input | 4 | Operation code carried to dispatch |
| iss_src_a | input | 3 | First source register |
| iss_src_b | input | 3 | Second source register |
| iss_dst | input | 3 | Destination register |
| iss_tag | output | 3 | Tag the issuing instruction receives |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 3 | Tag of the broadcast result |
| cdb_value | input | 32 | Broadcast result value |
| dsp_valid | output | 1 | A ready station is offered |
| dsp_ready | input | 1 | Functional unit accepts the offer |
| dsp_tag | output | 3 | Tag of the offered station |
| dsp_op | output | 4 | Operation code of the offered station |
| dsp_a | output | 32 | First operand value |
| dsp_b | output | 32 | Second operand value |

## Verification
The bench targets a broadcast that two stations wait on at once. A design that captured it in only one of them would leave a station hanging, and the scoreboard would never see its dispatch. A chain of writers to one register shows whether a stale tag wrongly clears the register: a reader issued later would then dispatch early with an old value instead of waiting for the last writer. A broadcast that arrives in the same cycle as its consumer's issue exposes a missing bypass, which leaves the consumer waiting forever. Issue requests sent while the array is full must leave no trace. If they did, a phantom dispatch or a register stuck pending would appear.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_NUM_ST  = 4;
    localparam int RS_NUM_REG = 8;
    localparam int RS_DATA_W  = 32;
    localparam int RS_OP_W    = 4;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2
    } st_state_e;

    function automatic int tag_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign gnt[i]      = req[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | req[i];
    end

endmodule

// File: rtl/rs_status.sv
module rs_status #(
    parameter int NUM_REG = 8,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 3,
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  rd_a_reg,
    output logic [TAG_W-1:0]  rd_a_tag,
    output logic [DATA_W-1:0] rd_a_val,
    input  logic [REG_W-1:0]  rd_b_reg,
    output logic [TAG_W-1:0]  rd_b_tag,
    output logic [DATA_W-1:0] rd_b_val,
    input  logic              set_en,
    input  logic [REG_W-1:0]  set_reg,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value
);
    logic [TAG_W-1:0]  tag_q [NUM_REG];
    logic [DATA_W-1:0] val_q [NUM_REG];

    assign rd_a_tag = tag_q[rd_a_reg];
    assign rd_a_val = val_q[rd_a_reg];
    assign rd_b_tag = tag_q[rd_b_reg];
    assign rd_b_val = val_q[rd_b_reg];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REG; i++) begin
                tag_q[i] <= '0;
                val_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REG; i++) begin
                if (cdb_valid && tag_q[i] != '0 && tag_q[i] == cdb_tag) begin
                    val_q[i] <= cdb_value;
                    tag_q[i] <= '0;
                end
                if (set_en && set_reg == REG_W'(i)) begin
                    tag_q[i] <= set_tag;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_REG; g++) begin : g_chk
        // R9: a broadcast with another tag leaves a pending register untouched
        p_keep_other_tag_r9: assert property (@(posedge clk) disable iff (rst)
            (tag_q[g] != '0 && !(set_en && set_reg == REG_W'(g)) &&
             cdb_valid && cdb_tag != tag_q[g])
            |=> (tag_q[g] == $past(tag_q[g]) && val_q[g] == $past(val_q[g])));
    end

endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3,
    parameter int OP_W   = 4,
    parameter int MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic              alloc_a_ok,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic              alloc_b_ok,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic              take,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

    st_state_e         state;
    logic              a_ok, b_ok;
    logic [TAG_W-1:0]  a_tag, b_tag;

    assign busy  = (state != ST_FREE);
    assign ready = (state == ST_WAIT) && a_ok && b_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FREE;
            a_ok  <= 1'b0;
            b_ok  <= 1'b0;
            a_tag <= '0;
            b_tag <= '0;
            a_val <= '0;
            b_val <= '0;
            op    <= '0;
        end else if (alloc) begin
            state <= ST_WAIT;
            op    <= alloc_op;
            a_ok  <= alloc_a_ok;
            a_tag <= alloc_a_tag;
            a_val <= alloc_a_val;
            b_ok  <= alloc_b_ok;
            b_tag <= alloc_b_tag;
            b_val <= alloc_b_val;
        end else if (state == ST_WAIT) begin
            if (!a_ok && cdb_valid && cdb_tag == a_tag) begin
                a_ok  <= 1'b1;
                a_val <= cdb_value;
            end
            if (!b_ok && cdb_valid && cdb_tag == b_tag) begin
                b_ok  <= 1'b1;
                b_val <= cdb_value;
            end
            if (take) begin
                state <= ST_EXEC;
            end
        end else if (state == ST_EXEC && cdb_valid && cdb_tag == SELF) begin
            state <= ST_FREE;
        end
    end

    // R2: the allocator only hands out a free station
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (state == ST_FREE));

    // R6: dispatch only takes a station with both operands present
    p_take_ready_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> ready);

    // R4: a waiting operand names a real producer other than this station
    p_wait_tag_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !a_ok) |-> (a_tag != '0 && a_tag != SELF));

    // R8: an executing station stays busy until its own tag is broadcast
    p_hold_exec_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && !(cdb_valid && cdb_tag == SELF)) |=> busy);

endmodule

// File: rtl/rs_array.sv
module rs_array
    import rs_pkg::*;
#(
    parameter int NUM_ST  = RS_NUM_ST,
    parameter int NUM_REG = RS_NUM_REG,
    parameter int DATA_W  = RS_DATA_W,
    parameter int OP_W    = RS_OP_W,
    localparam int TAG_W  = tag_bits(NUM_ST),
    localparam int REG_W  = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_src_a,
    input  logic [REG_W-1:0]  iss_src_b,
    input  logic [REG_W-1:0]  iss_dst,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              dsp_valid,
    input  logic              dsp_ready,
    output logic [TAG_W-1:0]  dsp_tag,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b
);
    logic [TAG_W-1:0]  st_a_tag, st_b_tag;
    logic [DATA_W-1:0] rf_a_val, rf_b_val;
    logic              a_pend, b_pend, a_byp, b_byp, a_ok, b_ok;
    logic [DATA_W-1:0] a_val, b_val;
    logic              do_issue;

    logic [NUM_ST-1:0] busy_vec, ready_vec, free_gnt, dsp_gnt;
    logic [OP_W-1:0]   op_arr [NUM_ST];
    logic [DATA_W-1:0] a_arr  [NUM_ST];
    logic [DATA_W-1:0] b_arr  [NUM_ST];

    rs_status #(
        .NUM_REG (NUM_REG),
        .DATA_W  (DATA_W),
        .TAG_W   (TAG_W)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .rd_a_reg  (iss_src_a),
        .rd_a_tag  (st_a_tag),
        .rd_a_val  (rf_a_val),
        .rd_b_reg  (iss_src_b),
        .rd_b_tag  (st_b_tag),
        .rd_b_val  (rf_b_val),
        .set_en    (do_issue),
        .set_reg   (iss_dst),
        .set_tag   (iss_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value)
    );

    // operand resolution with same-cycle broadcast bypass
    assign a_pend = (st_a_tag != '0);
    assign b_pend = (st_b_tag != '0);
    assign a_byp  = a_pend && cdb_valid && (cdb_tag == st_a_tag);
    assign b_byp  = b_pend && cdb_valid && (cdb_tag == st_b_tag);
    assign a_ok   = !a_pend || a_byp;
    assign b_ok   = !b_pend || b_byp;
    assign a_val  = a_byp ? cdb_value : rf_a_val;
    assign b_val  = b_byp ? cdb_value : rf_b_val;

    rs_pick #(.N(NUM_ST)) u_free_pick (.req(~busy_vec), .gnt(free_gnt));
    rs_pick #(.N(NUM_ST)) u_dsp_pick  (.req(ready_vec), .gnt(dsp_gnt));

    assign iss_ready = ~&busy_vec;
    assign do_issue  = iss_valid && iss_ready;
    assign dsp_valid = |ready_vec;

    always_comb begin
        iss_tag = '0;
        dsp_tag = '0;
        dsp_op  = '0;
        dsp_a   = '0;
        dsp_b   = '0;
        for (int i = 0; i < NUM_ST; i++) begin
            if (free_gnt[i]) iss_tag = TAG_W'(i + 1);
            if (dsp_gnt[i]) begin
                dsp_tag = TAG_W'(i + 1);
                dsp_op  = op_arr[i];
                dsp_a   = a_arr[i];
                dsp_b   = b_arr[i];
            end
        end
    end

    for (genvar s = 0; s < NUM_ST; s++) begin : g_st
        rs_station #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .OP_W   (OP_W),
            .MY_TAG (s + 1)
        ) u_st (
            .clk         (clk),
            .rst         (rst),
            .alloc       (do_issue && free_gnt[s]),
            .alloc_op    (iss_op),
            .alloc_a_ok  (a_ok),
            .alloc_a_tag (st_a_tag),
            .alloc_a_val (a_val),
            .alloc_b_ok  (b_ok),
            .alloc_b_tag (st_b_tag),
            .alloc_b_val (b_val),
            .cdb_valid   (cdb_valid),
            .cdb_tag     (cdb_tag),
            .cdb_value   (cdb_value),
            .take        (dsp_gnt[s] && dsp_ready),
            .busy        (busy_vec[s]),
            .ready       (ready_vec[s]),
            .op          (op_arr[s]),
            .a_val       (a_arr[s]),
            .b_val       (b_arr[s])
        );
    end

    // R2: an accepted issue always receives a nonzero tag in range
    p_issue_tag_r2: assert property (@(posedge clk) disable iff (rst)
        do_issue |-> (iss_tag != '0 && iss_tag <= TAG_W'(NUM_ST)));

    // R7: a full array stays full until some result is broadcast
    p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!iss_ready && !cdb_valid) |=> !iss_ready);

    // R6: an offer not taken is still offered next cycle
    p_offer_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (dsp_valid && !dsp_ready) |=> dsp_valid);

    // R6: the offered tag names a real station
    p_dsp_tag_r6: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |-> (dsp_tag != '0 && dsp_tag <= TAG_W'(NUM_ST)));

endmodule

// File: tb/tb_rs_array.sv
module tb_rs_array;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic        iss_ready;
    logic [3:0]  iss_op = '0;
    logic [2:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic [2:0]  iss_tag;
    logic        cdb_valid = 1'b0;
    logic [2:0]  cdb_tag = '0;
    logic [31:0] cdb_value = '0;
    logic        dsp_valid;
    logic        dsp_ready = 1'b0;
    logic [2:0]  dsp_tag;
    logic [3:0]  dsp_op;
    logic [31:0] dsp_a, dsp_b;

    always #2.5 clk = ~clk;

    rs_array dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_tag(dsp_tag),
        .dsp_op(dsp_op), .dsp_a(dsp_a), .dsp_b(dsp_b)
    );

    typedef struct {
        logic [2:0]  tag;
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_dsp(input logic [2:0] t, input logic [3:0] o,
                              input logic [31:0] a, input logic [31:0] b,
                              input string req);
        exp_t e;
        e.tag = t; e.op = o; e.a = a; e.b = b; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: every handshake must match the oldest expected dispatch
    always @(negedge clk) begin
        if (!rst && dsp_valid && dsp_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected dispatch tag", 32'(dsp_tag), 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(dsp_tag == e.tag, e.req, "dispatch tag", 32'(dsp_tag), 32'(e.tag));
                check(dsp_op  == e.op,  e.req, "dispatch op",  32'(dsp_op),  32'(e.op));
                check(dsp_a   == e.a,   e.req, "operand a",    dsp_a,        e.a);
                check(dsp_b   == e.b,   e.req, "operand b",    dsp_b,        e.b);
            end
        end
    end

    task automatic issue(input logic [3:0] o, input logic [2:0] sa,
                         input logic [2:0] sb, input logic [2:0] d,
                         input logic [2:0] exp_tag, input string req);
        iss_valid = 1'b1; iss_op = o; iss_src_a = sa; iss_src_b = sb; iss_dst = d;
        @(negedge clk);
        check(iss_ready == 1'b1, req, "iss_ready at issue", 32'(iss_ready), 32'h1);
        check(iss_tag == exp_tag, req, "issued tag", 32'(iss_tag), 32'(exp_tag));
        step();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input logic [2:0] t, input logic [31:0] v);
        cdb_valid = 1'b1; cdb_tag = t; cdb_value = v;
        step();
        cdb_valid = 1'b0;
    endtask

    task automatic dispatch(input int n);
        dsp_ready = 1'b1;
        repeat (n) step();
        dsp_ready = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(iss_ready == 1'b1, "R1", "iss_ready after reset", 32'(iss_ready), 32'h1);
        check(dsp_valid == 1'b0, "R1", "dsp_valid after reset", 32'(dsp_valid), 32'h0);
        step();

        // R3/R4/R5: one producer, two consumers waiting on it
        issue(4'd1, 3'd1, 3'd2, 3'd3, 3'd1, "R2");
        issue(4'd2, 3'd3, 3'd0, 3'd4, 3'd2, "R2");
        issue(4'd3, 3'd3, 3'd3, 3'd5, 3'd3, "R2");
        @(negedge clk);
        check(dsp_valid && dsp_tag == 3'd1, "R6", "only ready station offered", 32'(dsp_tag), 32'h1);
        expect_dsp(3'd1, 4'd1, 32'h0, 32'h0, "R3");
        step();
        dispatch(1);
        @(negedge clk);
        check(dsp_valid == 1'b0, "R6", "waiting stations not offered", 32'(dsp_valid), 32'h0);
        step();
        bcast(3'd1, 32'h11);
        @(negedge clk);
        check(dsp_valid && dsp_tag == 3'd2, "R5", "lowest of captured stations", 32'(dsp_tag), 32'h2);
        expect_dsp(3'd2, 4'd2, 32'h11, 32'h0, "R4");
        expect_dsp(3'd3, 4'd3, 32'h11, 32'h11, "R5");
        step();
        dispatch(2);
        bcast(3'd2, 32'h22);
        bcast(3'd3, 32'h33);

        // R11: cleared registers give broadcast values
        issue(4'd4, 3'd4, 3'd5, 3'd2, 3'd1, "R8");
        expect_dsp(3'd1, 4'd4, 32'h22, 32'h33, "R11");
        dispatch(1);
        bcast(3'd1, 32'h66);

        // R7: fill all stations, writers chained on r7
        issue(4'd5, 3'd0, 3'd0, 3'd7, 3'd1, "R2");
        issue(4'd6, 3'd0, 3'd0, 3'd7, 3'd2, "R2");
        issue(4'd7, 3'd0, 3'd0, 3'd7, 3'd3, "R2");
        issue(4'd8, 3'd0, 3'd0, 3'd7, 3'd4, "R2");
        @(negedge clk);
        check(iss_ready == 1'b0, "R7", "iss_ready when full", 32'(iss_ready), 32'h0);
        step();
        iss_valid = 1'b1; iss_op = 4'd9; iss_src_a = 3'd3; iss_src_b = 3'd3; iss_dst = 3'd6;
        step();
        iss_valid = 1'b0;
        @(negedge clk);
        check(iss_ready == 1'b0, "R7", "still full after refused issue", 32'(iss_ready), 32'h0);
        expect_dsp(3'd1, 4'd5, 32'h0, 32'h0, "R6");
        expect_dsp(3'd2, 4'd6, 32'h0, 32'h0, "R6");
        expect_dsp(3'd3, 4'd7, 32'h0, 32'h0, "R6");
        expect_dsp(3'd4, 4'd8, 32'h0, 32'h0, "R6");
        step();
        dispatch(4);
        @(negedge clk);
        check(dsp_valid == 1'b0, "R7", "refused issue left no station", 32'(dsp_valid), 32'h0);
        step();
        bcast(3'd1, 32'hA1);
        bcast(3'd2, 32'hA2);
        bcast(3'd3, 32'hA3);
        @(negedge clk);
        check(iss_ready == 1'b1, "R8", "stations freed by broadcast", 32'(iss_ready), 32'h1);
        step();

        // R9: r7 still waits on the last writer; r6 untouched by refused issue
        issue(4'd10, 3'd7, 3'd6, 3'd1, 3'd1, "R8");
        @(negedge clk);
        check(dsp_valid == 1'b0, "R9", "stale tags did not clear r7", 32'(dsp_valid), 32'h0);
        step();
        bcast(3'd4, 32'hA4);
        expect_dsp(3'd1, 4'd10, 32'hA4, 32'h0, "R9");
        dispatch(1);

        // R10: consumer issues in the cycle its producer broadcasts
        cdb_valid = 1'b1; cdb_tag = 3'd1; cdb_value = 32'hB1;
        issue(4'd11, 3'd1, 3'd7, 3'd2, 3'd2, "R10");
        cdb_valid = 1'b0;
        expect_dsp(3'd2, 4'd11, 32'hB1, 32'hA4, "R10");
        dispatch(1);
        issue(4'd12, 3'd1, 3'd1, 3'd1, 3'd1, "R11");
        expect_dsp(3'd1, 4'd12, 32'hB1, 32'hB1, "R11");
        dispatch(1);
        bcast(3'd2, 32'hC2);
        bcast(3'd1, 32'hC1);
        repeat (2) step();
        check(exp_q.size() == 0, "R6", "pending expected dispatches", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule